// File: doc/BRIEF.md
# Latched Serial-to-Parallel Channel Driver

This block is the logic side of a display column driver. A serial bit stream is clocked into a chain of shift stages, one stage per rising clock edge. A bank of level-sensitive latches copies the chain onto the parallel channels. The latches are transparent while the latch-enable input is high and keep their value while it is low. An output-enable input blanks every channel to logic low, or lets the latched pattern through. The last stage is also driven out as a serial cascade output, so that several drivers can share one clock, one latch enable and one output enable while their data runs through them in series.

The channel count is a parameter. A second parameter picks the order in which stages map to channels. In forward order, channel 1 is the stage that takes the serial input and the highest channel is the last stage. Reverse order swaps this mapping. An asynchronous active-low reset clears both the chain and the latches, so that simulation starts from a known state.

Top module: `serial_latch_driver`

## Requirements
- R1: On each rising edge of `clk`, stage 1 loads `ser_in` and every other stage loads the stage before it. Between rising edges the chain holds its contents.
- R2: `ser_out` always equals the last stage, so a bit applied on `ser_in` appears on `ser_out` after CHANNELS rising edges.
- R3: While `latch_en` is high, the latches follow the chain continuously, including changes caused by clock edges during that time.
- R4: While `latch_en` is low, the latches keep the value they had when it fell, and the chain keeps shifting normally.
- R5: With `out_en` low every bit of `ch_out` is 0. With `out_en` high each bit of `ch_out` shows its latch bit.
- R6: With ORDER = ORDER_FWD, `ch_out[0]` (channel 1) comes from stage 1, which holds the most recently shifted bit, and `ch_out[CHANNELS-1]` comes from the last stage.
- R7: With ORDER = ORDER_REV, `ch_out[k]` comes from stage CHANNELS-k, so `ch_out[0]` shows the last stage.
- R8: While `rst_n` is low, the chain and the latches are 0, so `ch_out` and `ser_out` are 0.
- R9: When the `ser_out` of one driver feeds the `ser_in` of a second, 2×CHANNELS shifts followed by a latch pulse put the first CHANNELS bits sent on the second driver and the last CHANNELS bits on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the chain and the latches |
| ser_in | input | 1 | Serial data into stage 1 |
| latch_en | input | 1 | High: the latches are transparent. Low: the latches hold |
| out_en | input | 1 | High: the channels show the latches. Low: all channels are 0 |
| ch_out | output | CHANNELS | Parallel channel outputs; bit k is channel k+1 |
| ser_out | output | 1 | Last stage of the chain, for cascading |

## Verification
The hold property samples `latch_en` only at rising clock edges. It therefore assumes that every high phase of latch enable spans at least one rising edge. A pulse that opens and closes the latches entirely between two edges would be invisible to it. The bench raises `latch_en` just after a rising edge and lowers it only after a later rising edge. It changes `ser_in`, `latch_en` and `out_en` away from the rising edge, which matches the setup-and-hold rule on the serial input. It runs four 64-bit patterns through two chained forward drivers and through one reverse-order driver, which sees the same input stream as the first forward driver.

// File: rtl/sld_pkg.sv
package sld_pkg;
   typedef enum logic {ORDER_FWD = 1'b0, ORDER_REV = 1'b1} order_e;
endpackage

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         din,
   output logic [N-1:0] stages,
   output logic         dout
);
   localparam int LAST = N - 1;

   if (N < 2) begin : g_bad_len
      $error("sld_shift_chain: N must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages <= '0;
      else        stages <= {stages[LAST-1:0], din};
   end

   assign dout = stages[LAST];

   // R1: stage 1 takes the serial input at each edge
   p_stage_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stages[0] == $past(din));

   // R2: the cascade output moves one stage per edge
   p_cascade_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> dout == $past(stages[LAST-1]));
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   always_latch begin
      if (!rst_n)  q = '0;
      else if (le) q = d;
   end

   // R3: transparent while enabled
   p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      le |-> q == d);

   // R4: holds across edges while disabled
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!le && $past(!le)) |-> $stable(q));
endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate
   import sld_pkg::*;
#(
   parameter int     N     = 32,
   parameter order_e ORDER = ORDER_FWD
) (
   input  logic [N-1:0] lat,
   input  logic         oe,
   output logic [N-1:0] ch
);
   logic [N-1:0] mapped;

   if (ORDER == ORDER_REV) begin : g_rev
      for (genvar k = 0; k < N; k++) begin : g_bit
         assign mapped[k] = lat[N-1-k];
      end
   end else begin : g_fwd
      assign mapped = lat;
   end

   assign ch = oe ? mapped : '0;
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
   import sld_pkg::*;
#(
   parameter int     CHANNELS = 32,
   parameter order_e ORDER    = ORDER_FWD
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_in,
   input  logic                latch_en,
   input  logic                out_en,
   output logic [CHANNELS-1:0] ch_out,
   output logic                ser_out
);
   localparam int FIRST_SRC = (ORDER == ORDER_REV) ? CHANNELS - 1 : 0;

   logic [CHANNELS-1:0] chain;
   logic [CHANNELS-1:0] held;

   sld_shift_chain #(.N(CHANNELS)) u_chain (
      .clk(clk), .rst_n(rst_n), .din(ser_in), .stages(chain), .dout(ser_out));

   sld_latch_bank #(.N(CHANNELS)) u_latch (
      .clk(clk), .rst_n(rst_n), .le(latch_en), .d(chain), .q(held));

   sld_out_gate #(.N(CHANNELS), .ORDER(ORDER)) u_gate (
      .lat(held), .oe(out_en), .ch(ch_out));

   // R5: blanking forces every channel low
   p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> ch_out == '0);

   // R6 / R7: channel 1 source depends on the order option
   p_first_channel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |-> ch_out[0] == held[FIRST_SRC]);

   // R8: reset clears the cascade output
   always_comb begin
      if (!rst_n) a_reset_clear_r8: assert (ser_out == 1'b0 || $isunknown(ser_out));
   end
endmodule

// File: tb/serial_latch_driver_tb.sv
module serial_latch_driver_tb;
   import sld_pkg::*;

   localparam int N = 32;

   logic clk = 1'b0;
   logic rst_n, ser_in, latch_en, out_en;
   logic [N-1:0] ch_a, ch_b, ch_r;
   logic so_a, so_b, so_r;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [2*N-1:0] sent;
   logic [2*N-1:0] lat_exp;

   always #5 clk = ~clk;

   serial_latch_driver #(.CHANNELS(N), .ORDER(ORDER_FWD)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
      .out_en(out_en), .ch_out(ch_a), .ser_out(so_a));

   serial_latch_driver #(.CHANNELS(N), .ORDER(ORDER_FWD)) u_next (
      .clk(clk), .rst_n(rst_n), .ser_in(so_a), .latch_en(latch_en),
      .out_en(out_en), .ch_out(ch_b), .ser_out(so_b));

   serial_latch_driver #(.CHANNELS(N), .ORDER(ORDER_REV)) u_rev (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
      .out_en(out_en), .ch_out(ch_r), .ser_out(so_r));

   task automatic check(string tag, logic [2*N-1:0] act, logic [2*N-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic logic [N-1:0] flip(logic [N-1:0] v);
      logic [N-1:0] r;
      for (int k = 0; k < N; k++) r[k] = v[N-1-k];
      return r;
   endfunction

   task automatic check_outputs(string tag, logic [2*N-1:0] lat, logic oe);
      logic [N-1:0] ea, eb, er;
      ea = oe ? lat[N-1:0] : '0;
      eb = oe ? lat[2*N-1:N] : '0;
      er = oe ? flip(lat[N-1:0]) : '0;
      check({tag, " first (R6)"}, {32'h0, ch_a}, {32'h0, ea});
      check({tag, " cascaded (R9)"}, {32'h0, ch_b}, {32'h0, eb});
      check({tag, " reverse (R7)"}, {32'h0, ch_r}, {32'h0, er});
   endtask

   // drive away from the edge, then check the cascade outputs 2 ns after it
   task automatic shift_bit(logic b);
      @(negedge clk);
      ser_in = b;
      @(posedge clk);
      #2;
      sent = {sent[2*N-2:0], b};
      check("R2 cascade out", {63'h0, so_a}, {63'h0, sent[N-1]});
      check("R2 reverse cascade out", {63'h0, so_r}, {63'h0, sent[N-1]});
      check("R9 second cascade out", {63'h0, so_b}, {63'h0, sent[2*N-1]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [2*N-1:0] pats [4];
      pats[0] = 64'hA5C3_0F96_1E2D_7B48;
      pats[1] = 64'h0000_0001_8000_0000;
      pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[3] = 64'h0123_4567_89AB_CDEF;

      rst_n = 1'b0; ser_in = 1'b0; latch_en = 1'b1; out_en = 1'b1;
      sent = '0; lat_exp = '0;
      #23;
      check_outputs("R8 reset", '0, 1'b1);
      check("R8 reset cascade", {63'h0, so_b}, 64'h0);
      latch_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int p = 0; p < 4; p++) begin
         for (int i = 2*N-1; i >= 0; i--) shift_bit(pats[p][i]);
         check_outputs("R4 hold during shifting", lat_exp, 1'b1);
         latch_en = 1'b1;
         #1;
         lat_exp = sent;
         check("R9 stream order", sent, pats[p]);
         check_outputs("R3 open latch", lat_exp, 1'b1);
         shift_bit(~pats[p][0]);
         #1;
         lat_exp = sent;
         check("R1 newest bit on channel 1", {63'h0, ch_a[0]}, {63'h0, ~pats[p][0]});
         check_outputs("R3 follows shift", lat_exp, 1'b1);
         latch_en = 1'b0;
         for (int i = 0; i < 5; i++) shift_bit(i[0]);
         check_outputs("R4 closed latch", lat_exp, 1'b1);
         out_en = 1'b0;
         #1;
         check_outputs("R5 blanked", lat_exp, 1'b0);
         out_en = 1'b1;
         #1;
         check_outputs("R5 unblanked", lat_exp, 1'b1);
      end

      rst_n = 1'b0;
      #1;
      check_outputs("R8 mid-run reset", '0, 1'b1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule